// File: doc/BRIEF.md
# Base-and-Bound Address Protection Unit

This unit sits between the CPU and the memory system and handles every byte address the processor issues. A request comes with a mode bit taken from the status word, the current base and bound values, and a 32-bit logical address. In system mode the address goes through unchanged as the physical address. In user mode the logical address is first compared with the bound. If it is below the bound, the base is added to form the physical address.

The physical address is then decoded into one of three regions. The low 16 MB is installed memory. The top sixteenth of the address space is memory-mapped I/O. The range between the two is unpopulated. An access that fails the bound check, or that lands in the unpopulated range, is aborted. It raises a program-error fault carrying parameter code 2 and asserts no memory or I/O strobe. All results are registered and appear one clock after the request.

Top module: `bnb_guard`

## Requirements
- R1: While reset is asserted and after it is released, with no request, `mem_sel_o`, `io_sel_o` and `fault_o` are 0, `fault_code_o` is 0 and `paddr_o` is 0.
- R2: Outputs for a request sampled at clock edge N appear after edge N and stay for one cycle. A cycle with `req_i` low yields all strobes, `fault_o`, `fault_code_o` and `paddr_o` at 0.
- R3: With `mode_i` = 0 (system mode), `paddr_o` equals the logical address. `base_i` and `bound_i` have no effect.
- R4: With `mode_i` = 1 (user mode) and a logical address strictly below `bound_i`, `paddr_o` equals `base_i` plus the logical address.
- R5: In user mode, a logical address greater than or equal to `bound_i` raises `fault_o` with `fault_code_o` = 2 and no strobe. The check uses the logical address before relocation.
- R6: Region decode works on the physical address. If it is at or above 0xF000_0000, `io_sel_o` is asserted. If it is below 0x0100_0000, `mem_sel_o` is asserted.
- R7: A physical address from 0x0100_0000 through 0xEFFF_FFFF raises `fault_o` with code 2 in either mode.
- R8: For a faulting access, `fault_o` is a single-cycle pulse per request, and `paddr_o` is 0. When `fault_o` is 0, `fault_code_o` is 0. At most one of `mem_sel_o`, `io_sel_o` and `fault_o` is high.
- R9: The relocation sum is taken modulo 2^32. A carry out of bit 31 is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Memory reference strobe |
| mode_i | input | 1 | Status word bit 0: 0 system, 1 user |
| base_i | input | 32 | Relocation base |
| bound_i | input | 32 | Exclusive upper limit on user logical addresses |
| vaddr_i | input | 32 | Logical byte address |
| paddr_o | output | 32 | Physical byte address (0 when idle or faulting) |
| mem_sel_o | output | 1 | Access goes to installed memory |
| io_sel_o | output | 1 | Access goes to I/O space |
| fault_o | output | 1 | Program-error fault pulse |
| fault_code_o | output | 4 | Fault parameter, 2 on a fault, else 0 |

## Verification
Several properties are checked by assertions on every cycle:
- the strobes and the fault are mutually exclusive;
- the fault code agrees with the fault;
- idle cycles leave the outputs quiet;
- a user request at or past the bound always faults;
- a system request into memory passes its address through unchanged.

Other behaviour can only be shown by the bench's directed scenarios. These cover the exact relocated value, the modulo-2^32 wraparound, and the edges of the memory and I/O regions. They also include a relocated address that falls into the unpopulated hole, and back-to-back requests that end a fault pulse after one cycle.

// File: rtl/bnb_pkg.sv
package bnb_pkg;
    typedef enum logic [1:0] {
        RGN_MEM  = 2'd0,
        RGN_IO   = 2'd1,
        RGN_HOLE = 2'd2
    } region_e;
endpackage

// File: rtl/bnb_limit_check.sv
module bnb_limit_check #(
    parameter int ADDR_W = 32
) (
    input  logic              user_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] bound_i,
    input  logic [ADDR_W-1:0] laddr_i,
    output logic [ADDR_W-1:0] paddr_o,
    output logic              over_o
);
    // Limit compare is on the logical address; relocation wraps at 2^ADDR_W.
    always_comb begin
        if (user_i) begin
            over_o  = (laddr_i >= bound_i);
            paddr_o = laddr_i + base_i;
        end else begin
            over_o  = 1'b0;
            paddr_o = laddr_i;
        end
    end
endmodule

// File: rtl/bnb_region_decode.sv
module bnb_region_decode
    import bnb_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] MEM_BYTES = 32'h0100_0000,
    parameter logic [ADDR_W-1:0] IO_BASE   = 32'hF000_0000
) (
    input  logic [ADDR_W-1:0] paddr_i,
    output region_e           region_o
);
    always_comb begin
        if (paddr_i >= IO_BASE)
            region_o = RGN_IO;
        else if (paddr_i < MEM_BYTES)
            region_o = RGN_MEM;
        else
            region_o = RGN_HOLE;
    end
endmodule

// File: rtl/bnb_guard.sv
module bnb_guard
    import bnb_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                CODE_W     = 4,
    parameter logic [ADDR_W-1:0] MEM_BYTES  = 32'h0100_0000,
    parameter logic [ADDR_W-1:0] IO_BASE    = 32'hF000_0000,
    parameter logic [CODE_W-1:0] CODE_RANGE = 4'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] bound_i,
    input  logic [ADDR_W-1:0] vaddr_i,
    output logic [ADDR_W-1:0] paddr_o,
    output logic              mem_sel_o,
    output logic              io_sel_o,
    output logic              fault_o,
    output logic [CODE_W-1:0] fault_code_o
);
    localparam logic [ADDR_W-1:0] ZERO_ADDR = '0;
    localparam logic [CODE_W-1:0] ZERO_CODE = '0;

    typedef struct packed {
        logic [ADDR_W-1:0] paddr;
        logic              mem;
        logic              io;
        logic              fault;
        logic [CODE_W-1:0] code;
    } resp_t;

    localparam resp_t RESP_IDLE = '{paddr: ZERO_ADDR, mem: 1'b0, io: 1'b0,
                                    fault: 1'b0, code: ZERO_CODE};

    logic [ADDR_W-1:0] reloc_addr;
    logic              over_limit;
    region_e           region;
    resp_t             resp_d, resp_q;

    bnb_limit_check #(.ADDR_W(ADDR_W)) u_limit (
        .user_i  (mode_i),
        .base_i  (base_i),
        .bound_i (bound_i),
        .laddr_i (vaddr_i),
        .paddr_o (reloc_addr),
        .over_o  (over_limit)
    );

    bnb_region_decode #(
        .ADDR_W    (ADDR_W),
        .MEM_BYTES (MEM_BYTES),
        .IO_BASE   (IO_BASE)
    ) u_region (
        .paddr_i  (reloc_addr),
        .region_o (region)
    );

    always_comb begin
        resp_d = RESP_IDLE;
        if (req_i) begin
            if (over_limit || region == RGN_HOLE) begin
                resp_d.fault = 1'b1;
                resp_d.code  = CODE_RANGE;
            end else begin
                resp_d.paddr = reloc_addr;
                resp_d.mem   = (region == RGN_MEM);
                resp_d.io    = (region == RGN_IO);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= RESP_IDLE;
        else        resp_q <= resp_d;
    end

    assign paddr_o      = resp_q.paddr;
    assign mem_sel_o    = resp_q.mem;
    assign io_sel_o     = resp_q.io;
    assign fault_o      = resp_q.fault;
    assign fault_code_o = resp_q.code;

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_sel_o, io_sel_o, fault_o}));

    assert_code_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o ? (fault_code_o == CODE_RANGE && paddr_o == ZERO_ADDR)
                : (fault_code_o == ZERO_CODE));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !mem_sel_o && !io_sel_o && !fault_o && paddr_o == ZERO_ADDR);

    assert_user_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && mode_i && (vaddr_i >= bound_i) |=> fault_o && !mem_sel_o && !io_sel_o);

    assert_system_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && !mode_i && (vaddr_i < MEM_BYTES) |=> mem_sel_o && paddr_o == $past(vaddr_i));

    assert_io_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel_o |-> paddr_o >= IO_BASE);

    assert_mem_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel_o |-> paddr_o < MEM_BYTES);
endmodule

// File: tb/test_bnb_guard.sv
module test_bnb_guard;
    localparam int CLK_PERIOD = 10;
    localparam int KIND_MEM = 0, KIND_IO = 1, KIND_FAULT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [31:0] base_i = '0, bound_i = '0, vaddr_i = '0;
    logic [31:0] paddr_o;
    logic        mem_sel_o, io_sel_o, fault_o;
    logic [3:0]  fault_code_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bnb_guard i_bnb_guard (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
        .base_i(base_i), .bound_i(bound_i), .vaddr_i(vaddr_i),
        .paddr_o(paddr_o), .mem_sel_o(mem_sel_o), .io_sel_o(io_sel_o),
        .fault_o(fault_o), .fault_code_o(fault_code_o)
    );

    task automatic check_out(input string tag, input int kind, input logic [31:0] pa);
        logic [38:0] got, exp;
        got = {paddr_o, mem_sel_o, io_sel_o, fault_o, fault_code_o};
        case (kind)
            KIND_MEM:   exp = {pa, 1'b1, 1'b0, 1'b0, 4'd0};
            KIND_IO:    exp = {pa, 1'b0, 1'b1, 1'b0, 4'd0};
            KIND_FAULT: exp = {32'd0, 1'b0, 1'b0, 1'b1, 4'd2};
            default:    exp = '0;
        endcase
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got pa=%h mem=%b io=%b flt=%b code=%0d exp pa=%h mem=%b io=%b flt=%b code=%0d",
                     tag, got[38:7], got[6], got[5], got[4], got[3:0],
                     exp[38:7], exp[6], exp[5], exp[4], exp[3:0]);
        end
    endtask

    task automatic check_idle(input string tag);
        checks++;
        if ({paddr_o, mem_sel_o, io_sel_o, fault_o, fault_code_o} !== 39'd0) begin
            errors++;
            $display("FAIL %s: got pa=%h mem=%b io=%b flt=%b code=%0d exp all zero",
                     tag, paddr_o, mem_sel_o, io_sel_o, fault_o, fault_code_o);
        end
    endtask

    // One request, result checked one edge later, then an idle cycle.
    task automatic access(input string tag, input logic mode, input logic [31:0] base,
                          input logic [31:0] bound, input logic [31:0] va,
                          input int kind, input logic [31:0] pa);
        @(negedge clk);
        req_i = 1'b1; mode_i = mode; base_i = base; bound_i = bound; vaddr_i = va;
        @(negedge clk);
        req_i = 1'b0;
        check_out(tag, kind, pa);
        @(negedge clk);
        check_idle({tag, " idle after (R2 R8)"});
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_idle("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");
    endtask

    task automatic test_system();
        access("R3 sys pass, base/bound ignored", 1'b0, 32'h0000_5000, 32'h10, 32'h0000_1234, KIND_MEM, 32'h0000_1234);
        access("R6 sys top of memory", 1'b0, 32'hFFFF_0000, 32'h0, 32'h00FF_FFFF, KIND_MEM, 32'h00FF_FFFF);
        access("R6 sys io base", 1'b0, 32'h1, 32'h1, 32'hF000_0000, KIND_IO, 32'hF000_0000);
        access("R6 sys io top", 1'b0, 32'h0, 32'h0, 32'hFFFF_FFFF, KIND_IO, 32'hFFFF_FFFF);
        access("R7 sys hole low edge", 1'b0, 32'h0, 32'h0, 32'h0100_0000, KIND_FAULT, 32'h0);
        access("R7 sys hole high edge", 1'b0, 32'h0, 32'h0, 32'hEFFF_FFFF, KIND_FAULT, 32'h0);
    endtask

    task automatic test_user();
        access("R4 user relocate", 1'b1, 32'h0000_2000, 32'h1000, 32'h100, KIND_MEM, 32'h0000_2100);
        access("R4 user last legal", 1'b1, 32'h0000_2000, 32'h1000, 32'hFFF, KIND_MEM, 32'h0000_2FFF);
        access("R5 user at bound", 1'b1, 32'h0000_2000, 32'h1000, 32'h1000, KIND_FAULT, 32'h0);
        access("R5 user zero bound", 1'b1, 32'h0, 32'h0, 32'h0, KIND_FAULT, 32'h0);
        access("R5 check before relocation", 1'b1, 32'h0, 32'h100, 32'hF000_0000, KIND_FAULT, 32'h0);
        access("R6 user into io", 1'b1, 32'hF000_0000, 32'h100, 32'h20, KIND_IO, 32'hF000_0020);
        access("R9 user wraparound", 1'b1, 32'hFFFF_FF00, 32'h1000, 32'h200, KIND_MEM, 32'h0000_0100);
        access("R7 user relocated into hole", 1'b1, 32'h00FF_FF00, 32'h1000, 32'h200, KIND_FAULT, 32'h0);
    endtask

    task automatic test_back_to_back();
        @(negedge clk);
        req_i = 1'b1; mode_i = 1'b1; base_i = 32'h400; bound_i = 32'h80; vaddr_i = 32'h80;
        @(negedge clk);
        check_out("R8 b2b first faults", KIND_FAULT, 32'h0);
        vaddr_i = 32'h7F;
        @(negedge clk);
        req_i = 1'b0;
        check_out("R8 fault lasts one cycle", KIND_MEM, 32'h47F);
        @(negedge clk);
        check_idle("R2 b2b idle");
    endtask

    initial begin
        test_reset();
        test_system();
        test_user();
        test_back_to_back();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout exp completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule